// File: doc/BRIEF.md
# Dual-Output Interrupt Cause Controller

This block gathers event pulses from the internal sources of a bridge or root-port style peripheral and reports them to a processor on two level-sensitive interrupt lines. Each event sets a sticky bit in a single cause register. A single unmask register decides which of those pending bits may reach an output. The masked result is split by fixed bit groups. The four legacy INTx events drive one line. Every other event drives the second line, which covers errors, power-management notifications and other custom conditions.

Software reads the cause register freely, because a read changes nothing. It acknowledges events one by one by writing 1 to the bits it has handled. Two handlers can therefore share the register: each clears only its own bits, and a line stays asserted while any other qualifying event is still pending.

Top module: `irq_cause_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the cause register, the unmask register and both interrupt outputs to zero.
- R2: A 1 on evt_in[i] sets cause bit i at the next clock edge, whether or not bit i is unmasked. A masked pending bit drives its output as soon as it is unmasked.
- R3: reg_rdata shows the cause register while reg_addr is 0 and the unmask register while reg_addr is 1, combinationally. A read has no side effect, so repeated reads return the same value.
- R4: A write to address 0 clears exactly the cause bits whose reg_wdata bit is 1. Bits written with 0 keep their value.
- R5: A write to address 1 loads reg_wdata into the unmask register unchanged.
- R6: intx_irq is high when any of cause bits 24 to 27 is both pending and unmasked.
- R7: err_irq is high when any cause bit outside 24 to 27 (for example bit 16, bit 0) is both pending and unmasked. Bits 24 to 27 never affect err_irq.
- R8: When evt_in[i] and a write-1-to-clear of bit i occur in the same cycle, cause bit i stays set.
- R9: Clearing one event of a group while another event of the same group stays pending and unmasked keeps that group's output asserted.
- R10: Both outputs are registered: they follow the cause and unmask state one clock edge after that state changes.
- R11: Addresses 2 and 3 read as zero, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 32 | One-cycle event pulses, one per cause bit |
| reg_addr | input | 2 | Register word address: 0 cause, 1 unmask |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data; for the cause register, 1 clears a bit |
| reg_rdata | output | 32 | Combinational read data for the addressed register |
| intx_irq | output | 1 | Level interrupt for the INTx group, bits 24 to 27 |
| err_irq | output | 1 | Level interrupt for all other cause bits |

## Verification
The assertions assume that reg_addr, reg_we, reg_wdata and evt_in are steady around each rising edge. They also assume that a write strobe means one write per cycle, with no read handshake. The stimulus drives every input only on the falling edge, so each value is held for a full half period before it is sampled. Within one cycle the stimulus may combine an event pulse with a write to the same bit, which is the overlap the same-cycle rule covers. Write data to unused addresses is arbitrary, so the bench writes all ones there to expose any decode leak.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

    localparam int unsigned MAX_W = 64;

    typedef enum logic [1:0] {
        SEL_CAUSE  = 2'd0,
        SEL_UNMASK = 2'd1,
        SEL_NONE   = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic intx;
        logic err;
    } irq_lines_t;

    function automatic reg_sel_e decode_addr(input int unsigned a);
        case (a)
            0:       return SEL_CAUSE;
            1:       return SEL_UNMASK;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [MAX_W-1:0] group_mask(input int unsigned lsb,
                                                    input int unsigned cnt);
        logic [MAX_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < MAX_W; i++) begin
            if (i >= lsb && i < lsb + cnt) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_cause_store.sv
module irq_cause_store #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] evt,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] cause
);
    logic [DATA_W-1:0] clr_eff;
    logic [DATA_W-1:0] cause_d;

    always_comb begin
        clr_eff = clr_we ? clr_bits : '0;
        // set wins over clear in the same cycle
        cause_d = (cause & ~clr_eff) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) cause <= '0;
        else     cause <= cause_d;
    end
endmodule

// File: rtl/irq_unmask_reg.sv
module irq_unmask_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] unmask
);
    always_ff @(posedge clk) begin
        if (rst)     unmask <= '0;
        else if (we) unmask <= wdata;
    end
endmodule

// File: rtl/irq_line_split.sv
module irq_line_split
    import irq_cause_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned INTX_LSB = 24,
    parameter int unsigned INTX_CNT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] cause,
    input  logic [DATA_W-1:0] unmask,
    output irq_lines_t        lines
);
    logic [DATA_W-1:0] in_intx;
    logic [DATA_W-1:0] live;
    irq_lines_t        lines_d;

    for (genvar i = 0; i < DATA_W; i++) begin : g_member
        if (i >= INTX_LSB && i < INTX_LSB + INTX_CNT) begin : g_intx
            assign in_intx[i] = 1'b1;
        end else begin : g_other
            assign in_intx[i] = 1'b0;
        end
    end

    always_comb begin
        live         = cause & unmask;
        lines_d.intx = |(live & in_intx);
        lines_d.err  = |(live & ~in_intx);
    end

    always_ff @(posedge clk) begin
        if (rst) lines <= '0;
        else     lines <= lines_d;
    end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irq_cause_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned INTX_LSB = 24,
    parameter int unsigned INTX_CNT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] evt_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              intx_irq,
    output logic              err_irq
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] cause_q;
    logic [DATA_W-1:0] unmask_q;
    logic              cause_wr;
    logic              unmask_wr;
    irq_lines_t        lines;

    always_comb begin
        sel       = decode_addr(int'(reg_addr));
        cause_wr  = reg_we && (sel == SEL_CAUSE);
        unmask_wr = reg_we && (sel == SEL_UNMASK);
        case (sel)
            SEL_CAUSE:  reg_rdata = cause_q;
            SEL_UNMASK: reg_rdata = unmask_q;
            default:    reg_rdata = '0;
        endcase
    end

    irq_cause_store #(.DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_in),
        .clr_we   (cause_wr),
        .clr_bits (reg_wdata),
        .cause    (cause_q)
    );

    irq_unmask_reg #(.DATA_W(DATA_W)) u_unmask (
        .clk    (clk),
        .rst    (rst),
        .we     (unmask_wr),
        .wdata  (reg_wdata),
        .unmask (unmask_q)
    );

    irq_line_split #(
        .DATA_W   (DATA_W),
        .INTX_LSB (INTX_LSB),
        .INTX_CNT (INTX_CNT)
    ) u_split (
        .clk    (clk),
        .rst    (rst),
        .cause  (cause_q),
        .unmask (unmask_q),
        .lines  (lines)
    );

    assign intx_irq = lines.intx;
    assign err_irq  = lines.err;
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk
    import irq_cause_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned INTX_LSB = 24,
    parameter int unsigned INTX_CNT = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] evt_in,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] cause,
    input logic [DATA_W-1:0] unmask,
    input logic              intx_irq,
    input logic              err_irq
);
    localparam logic [MAX_W-1:0] GRP_WIDE = group_mask(INTX_LSB, INTX_CNT);
    localparam logic [DATA_W-1:0] GRP = GRP_WIDE[DATA_W-1:0];

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cause == '0 && unmask == '0 && !intx_irq && !err_irq));

    p_sticky_set_r2: assert property (@(posedge clk) disable iff (rst)
        (|evt_in) |=> ((cause & $past(evt_in)) == $past(evt_in)));

    p_no_stray_clear_r4: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == ADDR_W'(0))
        |=> ((cause & $past(cause)) == $past(cause)));

    p_unmask_load_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_W'(1)) |=> (unmask == $past(reg_wdata)));

    p_intx_level_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (intx_irq == $past(|(cause & unmask & GRP))));

    p_err_level_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (err_irq == $past(|(cause & unmask & ~GRP))));

    p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_W'(0) && |(reg_wdata & evt_in))
        |=> ((cause & $past(reg_wdata & evt_in)) == $past(reg_wdata & evt_in)));

    p_spare_addr_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr >= ADDR_W'(2) && evt_in == '0)
        |=> (cause == $past(cause) && unmask == $past(unmask)));
endmodule

bind irq_cause_ctrl irq_cause_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .INTX_LSB (INTX_LSB),
    .INTX_CNT (INTX_CNT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_in    (evt_in),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .cause     (cause_q),
    .unmask    (unmask_q),
    .intx_irq  (intx_irq),
    .err_irq   (err_irq)
);

// File: tb/sim_irq_cause_ctrl.sv
`timescale 1ns/1ps
module sim_irq_cause_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt_in = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        intx_irq;
    logic        err_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    irq_cause_ctrl u0 (
        .clk(clk), .rst(rst), .evt_in(evt_in), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .intx_irq(intx_irq), .err_irq(err_irq)
    );

    // behavioural reference, written from the requirements
    localparam logic [31:0] INTX_BITS = 32'h0F00_0000;
    logic [31:0] m_cause = '0, m_unmask = '0;
    bit m_intx = 0, m_err = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cause <= '0; m_unmask <= '0; m_intx <= 0; m_err <= 0;
        end else begin
            m_intx <= (m_cause & m_unmask & INTX_BITS) != 0;
            m_err  <= (m_cause & m_unmask & ~INTX_BITS) != 0;
            m_cause <= (m_cause & ~((reg_we && reg_addr == 2'd0) ? reg_wdata : 32'h0)) | evt_in;
            if (reg_we && reg_addr == 2'd1) m_unmask <= reg_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison of both lines against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6 intx vs model", 32'(intx_irq), 32'(m_intx));
            chk("R7 err vs model",  32'(err_irq),  32'(m_err));
        end
    end

    task automatic tick(input logic [1:0] a, input logic w, input logic [31:0] d,
                        input logic [31:0] e);
        @(negedge clk);
        reg_addr = a; reg_we = w; reg_wdata = d; evt_in = e;
    endtask

    task automatic idle();
        tick(2'd0, 1'b0, 32'h0, 32'h0);
    endtask

    task automatic rd(input logic [1:0] a, input string tag, input logic [31:0] exp);
        tick(a, 1'b0, 32'h0, 32'h0);
        #1;
        chk(tag, reg_rdata, exp);
        chk({tag, " model"}, reg_rdata, a == 2'd0 ? m_cause : a == 2'd1 ? m_unmask : 32'h0);
    endtask

    task automatic lines(input bit i, input bit e, input string tag);
        chk({tag, " intx"}, 32'(intx_irq), 32'(i));
        chk({tag, " err"},  32'(err_irq),  32'(e));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        lines(0, 0, "R1 reset");
        rst = 1'b0;
        rd(2'd0, "R1 cause after reset", 32'h0);
        rd(2'd1, "R1 unmask after reset", 32'h0);

        // masked events still latch
        tick(2'd0, 1'b0, 32'h0, 32'h0201_0000);
        rd(2'd0, "R2 sticky masked set", 32'h0201_0000);
        rd(2'd0, "R3 reread unchanged", 32'h0201_0000);
        idle();
        lines(0, 0, "R2 masked no line");

        // unmask, outputs follow one edge later
        tick(2'd1, 1'b1, 32'h0F01_0000, 32'h0);
        rd(2'd1, "R5 unmask load", 32'h0F01_0000);
        lines(0, 0, "R10 not yet");
        idle();
        lines(1, 1, "R10 both lines R6 R7");

        // clear bit 16 only
        tick(2'd0, 1'b1, 32'h0001_0000, 32'h0);
        rd(2'd0, "R4 w1c single bit", 32'h0200_0000);
        idle();
        lines(1, 0, "R7 err drops");

        // INTx group retrigger
        tick(2'd0, 1'b0, 32'h0, 32'h0500_0000);
        tick(2'd0, 1'b1, 32'h0200_0000, 32'h0);
        idle(); idle();
        lines(1, 0, "R9 intx retrigger");
        rd(2'd0, "R4 intx partial clear", 32'h0500_0000);

        // error group retrigger
        tick(2'd1, 1'b1, 32'h0F03_0000, 32'h0);
        tick(2'd0, 1'b0, 32'h0, 32'h0003_0000);
        idle(); idle();
        lines(1, 1, "R7 err two pending");
        tick(2'd0, 1'b1, 32'h0001_0000, 32'h0);
        idle(); idle();
        lines(1, 1, "R9 err retrigger");
        tick(2'd0, 1'b1, 32'h0002_0000, 32'h0);
        idle(); idle();
        lines(1, 0, "R9 err last cleared");

        // same-cycle set and clear
        tick(2'd0, 1'b1, 32'h0000_0020, 32'h0000_0020);
        rd(2'd0, "R8 set beats clear", 32'h0500_0020);
        tick(2'd0, 1'b1, 32'h0, 32'h0);
        rd(2'd0, "R4 zero write keeps", 32'h0500_0020);

        // INTx bits never reach err, masked bit 0 then unmasked
        tick(2'd1, 1'b1, 32'h0F00_0000, 32'h0);
        tick(2'd0, 1'b1, 32'hFFFF_FFFF, 32'h0);
        tick(2'd0, 1'b0, 32'h0, 32'h0800_0001);
        idle(); idle();
        lines(1, 0, "R7 intx bit not on err");
        tick(2'd1, 1'b1, 32'h0F00_0001, 32'h0);
        idle();
        lines(1, 0, "R10 unmask lag");
        idle();
        lines(1, 1, "R2 unmask pending asserts");

        // spare addresses
        tick(2'd2, 1'b1, 32'hFFFF_FFFF, 32'h0);
        tick(2'd3, 1'b1, 32'hFFFF_FFFF, 32'h0);
        rd(2'd2, "R11 spare reads zero", 32'h0);
        rd(2'd0, "R11 cause untouched", 32'h0800_0001);
        rd(2'd1, "R11 unmask untouched", 32'h0F00_0001);

        // reset in mid run
        @(negedge clk); rst = 1'b1; reg_we = 1'b0;
        @(negedge clk); rst = 1'b0;
        #1;
        lines(0, 0, "R1 mid-run reset lines");
        rd(2'd0, "R1 mid-run reset cause", 32'h0);
        rd(2'd1, "R1 mid-run reset unmask", 32'h0);
        idle(); idle();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule